// File: doc/BRIEF.md
# Cipher Self-Test Loop Controller

This block drives an external block-cipher core through a repeating known-answer test. A host fills a small set of registers and word memories over a serial link: a configuration word that picks the cipher family and key length, up to eight key words, up to four plaintext words and up to four expected-result words. A start command launches a loop. In each pass the controller feeds the key and then the plaintext to the core, waits for the core to finish, reads the result back and compares it word by word with the expected words.

A matching pass flips the `run_toggle` output and the next pass begins at once. A mismatch raises a sticky error flag, leaves `run_toggle` untouched and ends the loop. A stop command lets the pass in flight finish and then returns the controller to idle. Two families are supported: a 128-bit-block cipher with 128, 192 or 256-bit keys, and a 64-bit-block lightweight cipher with 80 or 128-bit keys.

Words move to the core on a valid/ready stream. The controller holds its word until the core accepts it. Results come back on a second valid/ready stream, whose ready the controller raises only while it is collecting results. The core may pace both streams freely.

Top module: `cipher_selftest_loop`

## Requirements
- R1: Serial frames use clock polarity 0 and phase 0, most significant bit first, while `spi_cs_n` is low. A frame is 40 bits: a command byte (bit 7 write enable, bits 6:4 target, bits 3:0 word address) followed by a 32-bit data word. A frame whose bit 7 is 0 has no effect.
- R2: Targets are decoded as 0 configuration, 1 key memory (8 words), 2 plaintext memory (4 words), 3 expected-result memory (4 words) and 4 control (data bit 0 start, data bit 1 stop). A write to an address at or past a memory's depth changes nothing.
- R3: Configuration bit 0 selects the family (0 wide-block, 1 lightweight) and bits 2:1 select the key size. For the wide-block family codes 0, 1 and 2/3 send 4, 6 and 8 key words. For the lightweight family code 0 sends 3 key words and any other code sends 4. Block words are 4 for wide-block and 2 for lightweight. Each pass sends key words 0 upward with `core_in_is_key` high, then block words 0 upward with `core_in_last` high on the final one.
- R4: While `core_in_valid` is high and `core_in_ready` is low, `core_in_data`, `core_in_is_key` and `core_in_valid` hold steady.
- R5: `core_start` is a one-cycle pulse at the start of every pass, in the same cycle as the first key word is offered.
- R6: After `core_done`, the controller accepts exactly as many result words as there are block words, through `core_out_valid`/`core_out_ready`, and compares result word i with expected word i. It never offers input and accepts output in the same cycle.
- R7: Each pass whose results all match flips `run_toggle` exactly once, and the next pass starts unless a stop is pending.
- R8: A pass with any mismatching word sets `loop_err`, does not flip `run_toggle` and returns to idle.
- R9: A start is honoured only in idle and clears `loop_err`. A stop during a loop ends it after the current pass completes. A stop received in idle is discarded.
- R10: After reset `loop_busy`, `loop_err`, `run_toggle`, `core_start`, `core_in_valid` and `core_out_ready` are all 0.
- R11: Configuration is captured at start. Writes to it during a loop change neither the word counts nor `core_cipher_sel`/`core_key_size` until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Serial frame select, active low |
| spi_mosi | input | 1 | Serial data from host |
| core_start | output | 1 | Pass start pulse to the cipher core |
| core_cipher_sel | output | 1 | Captured family select |
| core_key_size | output | 2 | Captured key-size code |
| core_in_valid | output | 1 | Input word valid |
| core_in_ready | input | 1 | Core accepts input word |
| core_in_data | output | 32 | Key or plaintext word |
| core_in_is_key | output | 1 | Current input word is a key word |
| core_in_last | output | 1 | Current input word is the final block word |
| core_done | input | 1 | Core finished the pass |
| core_out_valid | input | 1 | Result word valid |
| core_out_ready | output | 1 | Controller accepts result word |
| core_out_data | input | 32 | Result word |
| loop_busy | output | 1 | Loop active |
| loop_err | output | 1 | Sticky mismatch flag |
| run_toggle | output | 1 | Flips on every matching pass |

## Verification
A table covers all five family and key-size combinations. Each one tells apart the word counts a pass sends, because the expected words depend on exactly the key words folded in. The input stream is back-pressured in a repeating pattern and result words arrive with gaps, which separates correct holding and in-order comparison from a design that drops or skips words. Directed runs then change one thing at a time: a single corrupted expected word, a frame with the write bit clear, a write past a memory's depth, a stop sent while idle, and a configuration write in mid-loop. Each of these would fail the pass, or stop or hang the loop, if it leaked through.

// File: rtl/stl_pkg.sv
package stl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_LOAD_KEY  = 3'd1,
    ST_LOAD_DATA = 3'd2,
    ST_WAIT_DONE = 3'd3,
    ST_READ_OUT  = 3'd4,
    ST_COMPARE   = 3'd5
  } loop_state_t;

  localparam logic [2:0] TGT_CFG  = 3'd0;
  localparam logic [2:0] TGT_KEY  = 3'd1;
  localparam logic [2:0] TGT_PT   = 3'd2;
  localparam logic [2:0] TGT_REF  = 3'd3;
  localparam logic [2:0] TGT_CTRL = 3'd4;

  localparam int CFG_W = 3;

  // number of key words for a configuration code {size[1:0], family}
  function automatic logic [3:0] key_words(input logic [CFG_W-1:0] cfg);
    logic [3:0] n;
    if (cfg[0]) n = (cfg[2:1] == 2'd0) ? 4'd3 : 4'd4;
    else begin
      case (cfg[2:1])
        2'd0:    n = 4'd4;
        2'd1:    n = 4'd6;
        default: n = 4'd8;
      endcase
    end
    return n;
  endfunction

  function automatic logic [3:0] blk_words(input logic [CFG_W-1:0] cfg);
    return cfg[0] ? 4'd2 : 4'd4;
  endfunction

endpackage

// File: rtl/stl_spi_rx.sv
module stl_spi_rx #(
  parameter int CMD_W  = 8,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              wr_stb,
  output logic [2:0]        wr_tgt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data
);
  localparam int FRAME_W = CMD_W + WORD_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic [2:0]         sclk_sync;
  logic [1:0]         cs_sync;
  logic [1:0]         mosi_sync;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic               frame_done;
  logic               sclk_rise;

  assign sclk_rise = sclk_sync[1] & ~sclk_sync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      cs_sync   <= '1;
      mosi_sync <= '0;
    end else begin
      sclk_sync <= {sclk_sync[1:0], sclk};
      cs_sync   <= {cs_sync[0], cs_n};
      mosi_sync <= {mosi_sync[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      bit_cnt    <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (cs_sync[1]) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[FRAME_W-2:0], mosi_sync[1]};
        if (bit_cnt == LAST_BIT) begin
          bit_cnt    <= '0;
          frame_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assign wr_stb  = frame_done & shreg[FRAME_W-1];
  assign wr_tgt  = shreg[FRAME_W-2 -: 3];
  assign wr_addr = shreg[WORD_W +: ADDR_W];
  assign wr_data = shreg[WORD_W-1:0];

endmodule

// File: rtl/stl_host_regs.sv
module stl_host_regs
  import stl_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int KEY_DEPTH = 8,
  parameter int BLK_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_stb,
  input  logic [2:0]                   wr_tgt,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [WORD_W-1:0]            wr_data,
  input  logic [$clog2(KEY_DEPTH)-1:0] key_idx,
  input  logic [$clog2(BLK_DEPTH)-1:0] blk_idx,
  output logic [CFG_W-1:0]             cfg,
  output logic [WORD_W-1:0]            key_word,
  output logic [WORD_W-1:0]            pt_word,
  output logic [WORD_W-1:0]            ref_word,
  output logic                         start_p,
  output logic                         stop_p
);
  logic [WORD_W-1:0] key_mem [KEY_DEPTH];
  logic [WORD_W-1:0] pt_mem  [BLK_DEPTH];
  logic [WORD_W-1:0] ref_mem [BLK_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      start_p <= 1'b0;
      stop_p  <= 1'b0;
    end else begin
      start_p <= 1'b0;
      stop_p  <= 1'b0;
      if (wr_stb && wr_tgt == TGT_CFG)  cfg <= wr_data[CFG_W-1:0];
      if (wr_stb && wr_tgt == TGT_CTRL) begin
        start_p <= wr_data[0];
        stop_p  <= wr_data[1];
      end
    end
  end

  for (genvar e = 0; e < KEY_DEPTH; e++) begin : g_key
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_mem[e] <= '0;
      else if (wr_stb && wr_tgt == TGT_KEY && wr_addr == ADDR_W'(e))
        key_mem[e] <= wr_data;
    end
  end

  for (genvar e = 0; e < BLK_DEPTH; e++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pt_mem[e]  <= '0;
        ref_mem[e] <= '0;
      end else if (wr_stb && wr_addr == ADDR_W'(e)) begin
        if (wr_tgt == TGT_PT)  pt_mem[e]  <= wr_data;
        if (wr_tgt == TGT_REF) ref_mem[e] <= wr_data;
      end
    end
  end

  assign key_word = key_mem[key_idx];
  assign pt_word  = pt_mem[blk_idx];
  assign ref_word = ref_mem[blk_idx];

endmodule

// File: rtl/stl_loop_fsm.sv
module stl_loop_fsm
  import stl_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int KEY_DEPTH = 8,
  parameter int BLK_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_p,
  input  logic                         stop_p,
  input  logic [CFG_W-1:0]             cfg,
  input  logic [WORD_W-1:0]            key_word,
  input  logic [WORD_W-1:0]            pt_word,
  input  logic [WORD_W-1:0]            ref_word,
  output logic [$clog2(KEY_DEPTH)-1:0] key_idx,
  output logic [$clog2(BLK_DEPTH)-1:0] blk_idx,
  output logic                         core_start,
  output logic [CFG_W-1:0]             cfg_run,
  output logic                         core_in_valid,
  input  logic                         core_in_ready,
  output logic [WORD_W-1:0]            core_in_data,
  output logic                         core_in_is_key,
  output logic                         core_in_last,
  input  logic                         core_done,
  input  logic                         core_out_valid,
  output logic                         core_out_ready,
  input  logic [WORD_W-1:0]            core_out_data,
  output logic                         loop_busy,
  output logic                         loop_err,
  output logic                         run_toggle
);
  localparam int CNT_W  = $clog2(KEY_DEPTH + 1);
  localparam int KEY_AW = $clog2(KEY_DEPTH);
  localparam int BLK_AW = $clog2(BLK_DEPTH);

  loop_state_t      state;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] nk_q;
  logic [CNT_W-1:0] nb_q;
  logic             stop_pend;
  logic             mism;
  logic             in_hs;
  logic             key_end;
  logic             blk_end;

  assign core_in_valid  = (state == ST_LOAD_KEY) || (state == ST_LOAD_DATA);
  assign core_in_is_key = (state == ST_LOAD_KEY);
  assign core_in_data   = core_in_is_key ? key_word : pt_word;
  assign core_out_ready = (state == ST_READ_OUT);
  assign loop_busy      = (state != ST_IDLE);
  assign key_idx        = idx[KEY_AW-1:0];
  assign blk_idx        = idx[BLK_AW-1:0];
  assign in_hs          = core_in_valid & core_in_ready;
  assign key_end        = (idx == nk_q - 1'b1);
  assign blk_end        = (idx == nb_q - 1'b1);
  assign core_in_last   = (state == ST_LOAD_DATA) && blk_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      idx        <= '0;
      nk_q       <= '0;
      nb_q       <= '0;
      cfg_run    <= '0;
      stop_pend  <= 1'b0;
      mism       <= 1'b0;
      loop_err   <= 1'b0;
      run_toggle <= 1'b0;
      core_start <= 1'b0;
    end else begin
      core_start <= 1'b0;
      if (stop_p && state != ST_IDLE) stop_pend <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (start_p) begin
            loop_err   <= 1'b0;
            stop_pend  <= 1'b0;
            cfg_run    <= cfg;
            nk_q       <= CNT_W'(key_words(cfg));
            nb_q       <= CNT_W'(blk_words(cfg));
            idx        <= '0;
            core_start <= 1'b1;
            state      <= ST_LOAD_KEY;
          end
        end
        ST_LOAD_KEY: begin
          if (in_hs) begin
            if (key_end) begin
              idx   <= '0;
              state <= ST_LOAD_DATA;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_LOAD_DATA: begin
          if (in_hs) begin
            if (blk_end) begin
              idx   <= '0;
              state <= ST_WAIT_DONE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_WAIT_DONE: begin
          if (core_done) begin
            idx   <= '0;
            mism  <= 1'b0;
            state <= ST_READ_OUT;
          end
        end
        ST_READ_OUT: begin
          if (core_out_valid) begin
            if (core_out_data != ref_word) mism <= 1'b1;
            if (blk_end) state <= ST_COMPARE;
            else         idx   <= idx + 1'b1;
          end
        end
        ST_COMPARE: begin
          idx <= '0;
          if (mism) begin
            loop_err  <= 1'b1;
            stop_pend <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            run_toggle <= ~run_toggle;
            if (stop_pend || stop_p) begin
              stop_pend <= 1'b0;
              state     <= ST_IDLE;
            end else begin
              core_start <= 1'b1;
              state      <= ST_LOAD_KEY;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cipher_selftest_loop.sv
module cipher_selftest_loop
  import stl_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int CMD_W     = 8,
  parameter int KEY_DEPTH = 8,
  parameter int BLK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              core_start,
  output logic              core_cipher_sel,
  output logic [1:0]        core_key_size,
  output logic              core_in_valid,
  input  logic              core_in_ready,
  output logic [WORD_W-1:0] core_in_data,
  output logic              core_in_is_key,
  output logic              core_in_last,
  input  logic              core_done,
  input  logic              core_out_valid,
  output logic              core_out_ready,
  input  logic [WORD_W-1:0] core_out_data,
  output logic              loop_busy,
  output logic              loop_err,
  output logic              run_toggle
);
  localparam int ADDR_W = CMD_W - 4;
  localparam int KEY_AW = $clog2(KEY_DEPTH);
  localparam int BLK_AW = $clog2(BLK_DEPTH);

  logic              wr_stb;
  logic [2:0]        wr_tgt;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic [CFG_W-1:0]  cfg;
  logic [CFG_W-1:0]  cfg_run;
  logic [WORD_W-1:0] key_word;
  logic [WORD_W-1:0] pt_word;
  logic [WORD_W-1:0] ref_word;
  logic [KEY_AW-1:0] key_idx;
  logic [BLK_AW-1:0] blk_idx;
  logic              start_p;
  logic              stop_p;

  stl_spi_rx #(.CMD_W(CMD_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .wr_stb(wr_stb), .wr_tgt(wr_tgt), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  stl_host_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .KEY_DEPTH(KEY_DEPTH),
                  .BLK_DEPTH(BLK_DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
    .wr_data(wr_data), .key_idx(key_idx), .blk_idx(blk_idx), .cfg(cfg),
    .key_word(key_word), .pt_word(pt_word), .ref_word(ref_word),
    .start_p(start_p), .stop_p(stop_p)
  );

  stl_loop_fsm #(.WORD_W(WORD_W), .KEY_DEPTH(KEY_DEPTH), .BLK_DEPTH(BLK_DEPTH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p), .cfg(cfg),
    .key_word(key_word), .pt_word(pt_word), .ref_word(ref_word),
    .key_idx(key_idx), .blk_idx(blk_idx), .core_start(core_start), .cfg_run(cfg_run),
    .core_in_valid(core_in_valid), .core_in_ready(core_in_ready),
    .core_in_data(core_in_data), .core_in_is_key(core_in_is_key),
    .core_in_last(core_in_last), .core_done(core_done),
    .core_out_valid(core_out_valid), .core_out_ready(core_out_ready),
    .core_out_data(core_out_data), .loop_busy(loop_busy), .loop_err(loop_err),
    .run_toggle(run_toggle)
  );

  assign core_cipher_sel = cfg_run[0];
  assign core_key_size   = cfg_run[2:1];

endmodule

// File: rtl/stl_loop_checker.sv
module stl_loop_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_start,
  input logic              core_cipher_sel,
  input logic [1:0]        core_key_size,
  input logic              core_in_valid,
  input logic              core_in_ready,
  input logic [WORD_W-1:0] core_in_data,
  input logic              core_in_is_key,
  input logic              core_out_ready,
  input logic              loop_busy,
  input logic              loop_err,
  input logic              run_toggle
);
  assert_in_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_in_valid && !core_in_ready |=>
      core_in_valid && $stable(core_in_data) && $stable(core_in_is_key));

  assert_start_first_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> core_in_valid && core_in_is_key && loop_busy);

  assert_phase_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_in_valid, core_out_ready}));

  assert_toggle_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(run_toggle) |-> !loop_err && $past(loop_busy));

  assert_err_no_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_err) |-> $stable(run_toggle) && !loop_busy);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_busy |-> !core_in_valid && !core_out_ready && !core_start);

  assert_cfg_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    loop_busy && $past(loop_busy) |->
      $stable(core_key_size) && $stable(core_cipher_sel));
endmodule

bind cipher_selftest_loop stl_loop_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_start(core_start),
  .core_cipher_sel(core_cipher_sel), .core_key_size(core_key_size),
  .core_in_valid(core_in_valid), .core_in_ready(core_in_ready),
  .core_in_data(core_in_data), .core_in_is_key(core_in_is_key),
  .core_out_ready(core_out_ready), .loop_busy(loop_busy),
  .loop_err(loop_err), .run_toggle(run_toggle)
);

// File: tb/cipher_selftest_loop_bench.sv
module cipher_selftest_loop_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        core_start, core_cipher_sel, core_in_valid, core_in_is_key, core_in_last;
  logic [1:0]  core_key_size;
  logic [31:0] core_in_data;
  logic        core_in_ready = 1'b0;
  logic        core_done = 1'b0;
  logic        core_out_valid = 1'b0;
  logic [31:0] core_out_data = '0;
  logic        core_out_ready, loop_busy, loop_err, run_toggle;

  always #2 clk = ~clk;

  cipher_selftest_loop u_cipher_selftest_loop (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .core_start(core_start), .core_cipher_sel(core_cipher_sel),
    .core_key_size(core_key_size), .core_in_valid(core_in_valid),
    .core_in_ready(core_in_ready), .core_in_data(core_in_data),
    .core_in_is_key(core_in_is_key), .core_in_last(core_in_last),
    .core_done(core_done), .core_out_valid(core_out_valid),
    .core_out_ready(core_out_ready), .core_out_data(core_out_data),
    .loop_busy(loop_busy), .loop_err(loop_err), .run_toggle(run_toggle)
  );

  // ---------------- core stub ----------------
  logic [31:0] kacc, dbuf [4];
  int kcnt, dcnt, rec_nk, rec_nb, ph, dly, oidx, cyc;
  initial begin kacc = 0; kcnt = 0; dcnt = 0; rec_nk = 0; rec_nb = 0; ph = 0; dly = 0; oidx = 0; cyc = 0; end

  always @(posedge clk) begin
    cyc = cyc + 1;
    core_in_ready <= (cyc % 4 != 1);
    if (core_start) begin kacc = 0; kcnt = 0; dcnt = 0; end
    if (core_in_valid && core_in_ready) begin
      if (core_in_is_key) begin
        kacc = {kacc[30:0], kacc[31]} ^ core_in_data; kcnt = kcnt + 1;
      end else begin
        dbuf[dcnt % 4] = core_in_data; dcnt = dcnt + 1;
        if (core_in_last) begin rec_nk = kcnt; rec_nb = dcnt; ph = 1; dly = 5; end
      end
    end
    case (ph)
      1: begin dly = dly - 1; if (dly == 0) begin core_done <= 1'b1; ph = 3; oidx = 0; end end
      3: begin
        core_done <= 1'b0;
        if (core_out_valid && core_out_ready) begin
          core_out_valid <= 1'b0; oidx = oidx + 1;
          if (oidx == rec_nb) ph = 0;
        end else if (!core_out_valid) begin
          core_out_valid <= 1'b1;
          core_out_data  <= dbuf[oidx % 4] ^ kacc ^ (32'h9E37_0000 + 32'(oidx));
        end
      end
      default: ;
    endcase
  end

  // ---------------- monitors ----------------
  int tog_cnt = 0, start_cnt = 0;
  logic last_tog = 1'b0;
  always @(negedge clk) begin
    if (run_toggle !== last_tog) tog_cnt = tog_cnt + 1;
    last_tog = run_toggle;
    if (core_start === 1'b1) start_cnt = start_cnt + 1;
  end

  // ---------------- checking ----------------
  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic spi_frame(input logic [7:0] cmd, input logic [31:0] dat);
    logic [39:0] f;
    f = {cmd, dat};
    @(negedge clk); spi_cs_n = 1'b0;
    for (int b = 39; b >= 0; b--) begin
      spi_mosi = f[b];
      repeat (4) @(negedge clk); spi_sclk = 1'b1;
      repeat (4) @(negedge clk); spi_sclk = 1'b0;
    end
    repeat (4) @(negedge clk); spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] tgt, input logic [3:0] addr, input logic [31:0] dat);
    spi_frame({1'b1, tgt, addr}, dat);
  endtask

  logic [31:0] key_b [8];
  logic [31:0] pt_b  [4];

  function automatic logic [31:0] exp_word(input int i, input int nk);
    logic [31:0] acc = 0;
    for (int j = 0; j < nk; j++) acc = {acc[30:0], acc[31]} ^ key_b[j];
    return pt_b[i] ^ acc ^ (32'h9E37_0000 + 32'(i));
  endfunction

  task automatic load_test(input logic [2:0] cfg, input int nk, input int nb, input logic [31:0] salt);
    wr(3'd0, 4'd0, {29'd0, cfg});
    for (int j = 0; j < 8; j++) begin
      key_b[j] = (32'h0101_0101 * 32'(j + 3)) ^ salt;
      wr(3'd1, 4'(j), key_b[j]);
    end
    for (int i = 0; i < 4; i++) begin
      pt_b[i] = (32'h1357_9BDF + 32'(i) * 32'h0F0F_1111) ^ {salt[15:0], salt[31:16]};
      wr(3'd2, 4'(i), pt_b[i]);
    end
    for (int i = 0; i < nb; i++) wr(3'd3, 4'(i), exp_word(i, nk));
  endtask

  task automatic wait_toggles(input int target);
    for (int t = 0; t < 20000 && tog_cnt < target; t++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 20000 && loop_busy; t++) @(negedge clk);
  endtask

  // cfg {size[1:0], family}, key words, block words
  localparam logic [10:0] VEC [5] = '{
    {3'b000, 4'd4, 4'd4}, {3'b010, 4'd6, 4'd4}, {3'b100, 4'd8, 4'd4},
    {3'b001, 4'd3, 4'd2}, {3'b011, 4'd4, 4'd2}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0, s0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!loop_busy && !loop_err && !run_toggle && !core_start && !core_in_valid && !core_out_ready,
          "R10", "reset outputs", {loop_busy, loop_err, run_toggle, core_in_valid, core_out_ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R5 R6 R7 R9 table walk
    for (int v = 0; v < 5; v++) begin
      load_test(VEC[v][10:8], int'(VEC[v][7:4]), int'(VEC[v][3:0]), 32'hA5C3_0000 + 32'(v * 7919));
      t0 = tog_cnt; s0 = start_cnt;
      wr(3'd4, 4'd0, 32'h1);
      wait_toggles(t0 + 3);
      wr(3'd4, 4'd0, 32'h2);
      wait_idle();
      repeat (3) @(negedge clk);
      check(!loop_busy && !loop_err, "R9", "stopped cleanly", {loop_busy, loop_err}, 0);
      check(rec_nk == int'(VEC[v][7:4]), "R3", "key words per pass", rec_nk, VEC[v][7:4]);
      check(rec_nb == int'(VEC[v][3:0]), "R3", "block words per pass", rec_nb, VEC[v][3:0]);
      check(tog_cnt - t0 >= 3, "R7", "toggles while looping", tog_cnt - t0, 3);
      check(start_cnt - s0 == tog_cnt - t0, "R5", "start pulses equal matched passes",
            start_cnt - s0, tog_cnt - t0);
    end

    // R8 mismatch: corrupt expected word 1 in a wide-block 128-bit run
    load_test(3'b000, 4, 4, 32'h0BAD_F00D);
    wr(3'd3, 4'd1, exp_word(1, 4) ^ 32'h0000_0100);
    t0 = tog_cnt; s0 = start_cnt;
    wr(3'd4, 4'd0, 32'h1);
    wait_idle();
    repeat (3) @(negedge clk);
    check(loop_err === 1'b1, "R8", "error flag after mismatch", loop_err, 1);
    check(tog_cnt == t0, "R8", "no toggle on mismatch", tog_cnt - t0, 0);
    check(start_cnt - s0 == 1 && !loop_busy, "R8", "single pass then idle", start_cnt - s0, 1);

    // R1 frame with write bit clear: a start must not happen, error stays
    wr(3'd3, 4'd1, exp_word(1, 4));
    spi_frame({1'b0, 3'd4, 4'd0}, 32'h1);
    repeat (20) @(negedge clk);
    check(!loop_busy && loop_err, "R1", "non-write frame ignored", {loop_busy, loop_err}, 1);

    // R2 write past key depth ignored
    wr(3'd1, 4'd8, 32'hDEAD_BEEF);
    wr(3'd3, 4'd4, 32'hDEAD_BEEF);
    // R9 stop while idle is discarded; start clears error
    wr(3'd4, 4'd0, 32'h2);
    t0 = tog_cnt;
    wr(3'd4, 4'd0, 32'h1);
    repeat (10) @(negedge clk);
    check(loop_busy && !loop_err, "R9", "start clears error", {loop_busy, loop_err}, 2);
    repeat (400) @(negedge clk);
    check(loop_busy === 1'b1, "R9", "idle stop not latched", loop_busy, 1);
    check(!loop_err && tog_cnt - t0 >= 2, "R2", "out-of-range writes left memories intact",
          tog_cnt - t0, 2);

    // R11 config write during loop has no effect on the running pass
    wr(3'd0, 4'd0, 32'h1);
    repeat (200) @(negedge clk);
    check(core_cipher_sel == 1'b0 && core_key_size == 2'd0, "R11", "captured config held",
          {core_cipher_sel, core_key_size}, 0);
    wr(3'd4, 4'd0, 32'h2);
    wait_idle();
    repeat (3) @(negedge clk);
    check(!loop_err && rec_nk == 4, "R11", "key words unchanged mid-loop", rec_nk, 4);
    check(rec_nb == 4, "R6", "result words collected", rec_nb, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule